// File: doc/BRIEF.md
# Latching and Retry Current Limiter Trip Controller

This block holds the digital trip decision for a solid-state switch on a power line. The analog current limiter next to the switch raises an over-current flag while it is holding the load current at its limit. The block integrates the time that flag is up. Short bursts of over-current add up instead of being forgotten. When the integrated time reaches a trip limit, the switch is turned off. The trip limit is either a fixed constant or a constant scaled down by the voltage dropped across the switch. A large drop means more dissipation in the switch, so it gets a shorter allowance.

After a trip the block follows one of two policies. In the latching policy the switch stays off until the on/off command is released and asserted again. In the retry policy the switch is re-enabled after a programmable off time. After a programmable number of such retries the block gives up and raises an exhausted flag. A separate fold-back option tells the analog side to drop its current limit to a trickle level as soon as an overload is seen. The level returns to normal only after the fault time has fully drained away.

Top module: `lcl_trip_ctrl`

## Requirements
- R1: While reset is asserted, and on the cycle after it, the switch enable, the trickle select, the tripped flag and the exhausted flag are all 0 and the fault accumulator reads 0.
- R2: A 0-to-1 transition of the on command turns the switch on at the next clock edge. It clears the accumulator, a latched trip and the retry count. While the switch is on, dropping the command turns it off at the next edge.
- R3: While the switch is on and the over-current flag is high, the accumulator rises by exactly 1 per clock. It holds at its maximum value rather than wrapping. Separate over-current bursts add together.
- R4: When the over-current flag is not counted, the accumulator falls by 1 on every DECAY_DIV-th consecutive such clock and never goes below 0. With DECAY_DIV = 4, a value N left alone for m clocks reads max(0, N - floor(m/4)).
- R5: While the switch is off, the over-current flag does not raise the accumulator.
- R6: A trip occurs on the clock edge where the switch is on and the accumulator is at or above the trip limit L. Under continuous over-current from switch-on, the switch stays on for exactly L+1 clocks.
- R7: With the voltage-dependent mode off, L is FIXED_LIMIT (40 by default).
- R8: With the voltage-dependent mode on, L is BASE_LIMIT (320 by default) shifted right by the bit index of the most significant 1 in the drop code. A drop code of 0 gives BASE_LIMIT.
- R9: With the retry mode off, a trip turns the switch off and raises the tripped flag. Both stay that way, whether the command is held or released, until the next 0-to-1 transition of the command.
- R10: With the retry mode on, a trip holds the switch off for max(T,1) clocks, where T is the off-time input. The switch is then turned back on with the accumulator cleared. The tripped flag is high while the switch waits.
- R11: With the retry mode on and a retry limit M, the switch is turned on M+1 times in total under a persistent fault. The trip after the last of these sets the exhausted flag and keeps the switch off until the command is re-asserted.
- R12: With the fold-back mode on, the trickle select goes to 1 on the clock edge after over-current is counted. It returns to 0 on the first edge at which the accumulator already reads 0 and no over-current is counted. With fold-back off, the trickle select stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_on_i | input | 1 | On/off command; a rising transition re-arms the switch |
| oc_i | input | 1 | Over-current flag from the analog limiter |
| drop_i | input | DROP_W | Line-to-load voltage drop code |
| retry_mode_i | input | 1 | 1: retry after a trip, 0: latch off |
| vdep_mode_i | input | 1 | 1: trip limit depends on drop_i, 0: fixed limit |
| fold_mode_i | input | 1 | 1: enable the bistable fold-back to trickle level |
| off_time_i | input | OFF_W | Off time between retries, in clocks |
| max_retry_i | input | TRY_W | Number of retries allowed before giving up |
| sw_en_o | output | 1 | Switch enable |
| trickle_o | output | 1 | Current-limit level select: 1 selects trickle level |
| tripped_o | output | 1 | A trip is latched, waiting to retry, or exhausted |
| exhausted_o | output | 1 | Retries used up; switch locked off |
| acc_o | output | ACC_W | Fault-time accumulator value |

## Verification
The properties assume the mode inputs are stable while the switch is on and for one cycle around a change. They also assume the drop code does not change while the trip limit is being applied. The bench changes modes, drop code, off time and retry limit only while the command is low and the switch is idle or locked. It then raises the command at least two clocks later. Over-current is driven freely, including while the switch is off, because the accumulator must ignore it there.

// File: rtl/lcl_trip_pkg.sv
package lcl_trip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_LATCH = 3'd2,
    ST_WAIT  = 3'd3,
    ST_LOCK  = 3'd4
  } lcl_state_e;

endpackage

// File: rtl/lcl_fault_integ.sv
module lcl_fault_integ #(
  parameter int ACC_W     = 10,
  parameter int DECAY_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             oc_eff_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic dec_tick;

  generate
    if (DECAY_DIV <= 1) begin : g_every_clock
      assign dec_tick = ~oc_eff_i;
    end else begin : g_divided
      localparam int DW = $clog2(DECAY_DIV);
      localparam logic [DW-1:0] DLAST = DW'(DECAY_DIV - 1);
      logic [DW-1:0] dcnt;

      always_ff @(posedge clk) begin
        if (rst || clr_i || oc_eff_i) begin
          dcnt <= '0;
        end else if (dcnt == DLAST) begin
          dcnt <= '0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end

      assign dec_tick = ~oc_eff_i & (dcnt == DLAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_o <= '0;
    end else if (oc_eff_i) begin
      if (acc_o != ACC_MAX) acc_o <= acc_o + 1'b1;
    end else if (dec_tick && (acc_o != '0)) begin
      acc_o <= acc_o - 1'b1;
    end
  end

endmodule

// File: rtl/lcl_trip_limit.sv
module lcl_trip_limit #(
  parameter int ACC_W       = 10,
  parameter int DROP_W      = 6,
  parameter int FIXED_LIMIT = 40,
  parameter int BASE_LIMIT  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vdep_i,
  input  logic [DROP_W-1:0] drop_i,
  output logic [ACC_W-1:0]  limit_o
);

  localparam int SH_W = (DROP_W > 1) ? $clog2(DROP_W) : 1;
  localparam logic [ACC_W-1:0] FIX_L  = ACC_W'(FIXED_LIMIT);
  localparam logic [ACC_W-1:0] BASE_L = ACC_W'(BASE_LIMIT);

  logic [SH_W-1:0]  msb_idx;
  logic [ACC_W-1:0] limit_n;

  always_comb begin
    msb_idx = '0;
    for (int i = 1; i < DROP_W; i++) begin
      if (drop_i[i]) msb_idx = SH_W'(i);
    end
  end

  always_comb begin
    if (!vdep_i) begin
      limit_n = FIX_L;
    end else begin
      limit_n = BASE_L >> msb_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_o <= FIX_L;
    end else begin
      limit_o <= limit_n;
    end
  end

endmodule

// File: rtl/lcl_retry_fsm.sv
module lcl_retry_fsm
  import lcl_trip_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int TRY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic             rise_i,
  input  logic             trip_i,
  input  logic             retry_i,
  input  logic [OFF_W-1:0] off_time_i,
  input  logic [TRY_W-1:0] max_retry_i,
  output logic             restart_o,
  output logic             sw_en_o,
  output logic             tripped_o,
  output logic             exhausted_o
);

  lcl_state_e       state, state_n;
  logic [OFF_W-1:0] timer, timer_n;
  logic [TRY_W-1:0] tries, tries_n;

  always_comb begin
    state_n   = state;
    timer_n   = timer;
    tries_n   = tries;
    restart_o = 1'b0;
    unique case (state)
      ST_IDLE, ST_LATCH, ST_LOCK: begin
        if (rise_i) begin
          state_n = ST_ON;
          tries_n = '0;
        end
      end
      ST_ON: begin
        if (!cmd_i) begin
          state_n = ST_IDLE;
        end else if (trip_i) begin
          if (!retry_i) begin
            state_n = ST_LATCH;
          end else if (tries < max_retry_i) begin
            state_n = ST_WAIT;
            tries_n = tries + 1'b1;
            timer_n = (off_time_i == '0) ? '0 : off_time_i - 1'b1;
          end else begin
            state_n = ST_LOCK;
          end
        end
      end
      ST_WAIT: begin
        if (!cmd_i) begin
          state_n = ST_IDLE;
        end else if (timer == '0) begin
          state_n   = ST_ON;
          restart_o = 1'b1;
        end else begin
          timer_n = timer - 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      timer       <= '0;
      tries       <= '0;
      sw_en_o     <= 1'b0;
      tripped_o   <= 1'b0;
      exhausted_o <= 1'b0;
    end else begin
      state       <= state_n;
      timer       <= timer_n;
      tries       <= tries_n;
      sw_en_o     <= (state_n == ST_ON);
      tripped_o   <= (state_n == ST_LATCH) || (state_n == ST_WAIT) || (state_n == ST_LOCK);
      exhausted_o <= (state_n == ST_LOCK);
    end
  end

endmodule

// File: rtl/lcl_foldback.sv
module lcl_foldback (
  input  logic clk,
  input  logic rst,
  input  logic fold_i,
  input  logic clr_i,
  input  logic oc_eff_i,
  input  logic acc_zero_i,
  output logic trickle_o
);

  always_ff @(posedge clk) begin
    if (rst || !fold_i || clr_i) begin
      trickle_o <= 1'b0;
    end else if (oc_eff_i) begin
      trickle_o <= 1'b1;
    end else if (acc_zero_i) begin
      trickle_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lcl_trip_ctrl.sv
module lcl_trip_ctrl #(
  parameter int ACC_W       = 10,
  parameter int DECAY_DIV   = 4,
  parameter int DROP_W      = 6,
  parameter int FIXED_LIMIT = 40,
  parameter int BASE_LIMIT  = 320,
  parameter int OFF_W       = 8,
  parameter int TRY_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_on_i,
  input  logic              oc_i,
  input  logic [DROP_W-1:0] drop_i,
  input  logic              retry_mode_i,
  input  logic              vdep_mode_i,
  input  logic              fold_mode_i,
  input  logic [OFF_W-1:0]  off_time_i,
  input  logic [TRY_W-1:0]  max_retry_i,
  output logic              sw_en_o,
  output logic              trickle_o,
  output logic              tripped_o,
  output logic              exhausted_o,
  output logic [ACC_W-1:0]  acc_o
);

  logic             cmd_q;
  logic             cmd_rise;
  logic             restart;
  logic             acc_clr;
  logic             oc_eff;
  logic             trip;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= 1'b0;
    else     cmd_q <= cmd_on_i;
  end

  assign cmd_rise = cmd_on_i & ~cmd_q;
  assign acc_clr  = cmd_rise | restart;
  assign oc_eff   = oc_i & sw_en_o;
  assign trip     = sw_en_o & (acc >= limit);
  assign acc_o    = acc;

  lcl_fault_integ #(
    .ACC_W     (ACC_W),
    .DECAY_DIV (DECAY_DIV)
  ) integ_i (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (acc_clr),
    .oc_eff_i (oc_eff),
    .acc_o    (acc)
  );

  lcl_trip_limit #(
    .ACC_W       (ACC_W),
    .DROP_W      (DROP_W),
    .FIXED_LIMIT (FIXED_LIMIT),
    .BASE_LIMIT  (BASE_LIMIT)
  ) limit_i (
    .clk     (clk),
    .rst     (rst),
    .vdep_i  (vdep_mode_i),
    .drop_i  (drop_i),
    .limit_o (limit)
  );

  lcl_retry_fsm #(
    .OFF_W (OFF_W),
    .TRY_W (TRY_W)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd_on_i),
    .rise_i      (cmd_rise),
    .trip_i      (trip),
    .retry_i     (retry_mode_i),
    .off_time_i  (off_time_i),
    .max_retry_i (max_retry_i),
    .restart_o   (restart),
    .sw_en_o     (sw_en_o),
    .tripped_o   (tripped_o),
    .exhausted_o (exhausted_o)
  );

  lcl_foldback fold_i (
    .clk        (clk),
    .rst        (rst),
    .fold_i     (fold_mode_i),
    .clr_i      (acc_clr),
    .oc_eff_i   (oc_eff),
    .acc_zero_i (acc == '0),
    .trickle_o  (trickle_o)
  );

endmodule

// File: rtl/lcl_trip_ctrl_chk.sv
module lcl_trip_ctrl_chk #(
  parameter int ACC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_on_i,
  input logic             oc_i,
  input logic             retry_mode_i,
  input logic             fold_mode_i,
  input logic             sw_en_o,
  input logic             trickle_o,
  input logic             tripped_o,
  input logic             exhausted_o,
  input logic [ACC_W-1:0] acc_o
);

  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!sw_en_o && !tripped_o && !exhausted_o && !trickle_o && acc_o == '0));

  p_cmd_off_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_en_o && !cmd_on_i) |=> !sw_en_o);

  p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_en_o && cmd_on_i && oc_i && acc_o != ACC_MAX) |=> (acc_o == $past(acc_o) + 1'b1));

  p_decay_step_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_en_o && cmd_on_i && !oc_i && acc_o != '0)
      |=> (acc_o == $past(acc_o) || acc_o == $past(acc_o) - 1'b1));

  p_off_no_count_r5: assert property (@(posedge clk) disable iff (rst)
    !sw_en_o |=> (acc_o <= $past(acc_o)));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tripped_o && !retry_mode_i && !cmd_on_i) |=> (!sw_en_o && tripped_o));

  p_lock_from_on_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(exhausted_o) |-> $past(sw_en_o));

  p_lock_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (exhausted_o && !cmd_on_i) |=> (exhausted_o && !sw_en_o));

  p_fold_only_r12: assert property (@(posedge clk) disable iff (rst)
    !fold_mode_i |=> !trickle_o);

endmodule

bind lcl_trip_ctrl lcl_trip_ctrl_chk #(.ACC_W(ACC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmd_on_i     (cmd_on_i),
  .oc_i         (oc_i),
  .retry_mode_i (retry_mode_i),
  .fold_mode_i  (fold_mode_i),
  .sw_en_o      (sw_en_o),
  .trickle_o    (trickle_o),
  .tripped_o    (tripped_o),
  .exhausted_o  (exhausted_o),
  .acc_o        (acc_o)
);

// File: tb/lcl_trip_ctrl_tb_top.sv
module lcl_trip_ctrl_tb_top;

  localparam int ACC_W  = 10;
  localparam int DIV    = 4;
  localparam int DROP_W = 6;
  localparam int FIX    = 40;
  localparam int BASE   = 320;
  localparam int OFF_W  = 8;
  localparam int TRY_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_on = 1'b0;
  logic              oc = 1'b0;
  logic [DROP_W-1:0] drop = '0;
  logic              retry_mode = 1'b0;
  logic              vdep_mode = 1'b0;
  logic              fold_mode = 1'b0;
  logic [OFF_W-1:0]  off_time = '0;
  logic [TRY_W-1:0]  max_retry = '0;
  logic              sw_en, trickle, tripped, exhausted;
  logic [ACC_W-1:0]  acc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lcl_trip_ctrl #(
    .ACC_W(ACC_W), .DECAY_DIV(DIV), .DROP_W(DROP_W), .FIXED_LIMIT(FIX),
    .BASE_LIMIT(BASE), .OFF_W(OFF_W), .TRY_W(TRY_W)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_on_i(cmd_on), .oc_i(oc), .drop_i(drop),
    .retry_mode_i(retry_mode), .vdep_mode_i(vdep_mode), .fold_mode_i(fold_mode),
    .off_time_i(off_time), .max_retry_i(max_retry), .sw_en_o(sw_en),
    .trickle_o(trickle), .tripped_o(tripped), .exhausted_o(exhausted), .acc_o(acc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // release the command, then raise it; returns at the negedge after the enabling edge
  task automatic go_on();
    cmd_on = 1'b0;
    cyc(2);
    cmd_on = 1'b1;
    cyc(1);
  endtask

  task automatic measure(input logic level, output int n);
    n = 0;
    while (sw_en == level && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    cyc(3);
    chk(sw_en == 0 && tripped == 0 && exhausted == 0 && trickle == 0 && acc == 0,
        "R1 reset outputs", int'(sw_en) + int'(acc), 0);
    rst = 1'b0;
    cyc(1);
    chk(sw_en == 0 && acc == 0, "R1 after release", int'(sw_en), 0);

    // R5: over-current while the switch is off is not counted
    oc = 1'b1;
    cyc(20);
    chk(acc == 0, "R5 acc while off", int'(acc), 0);
    chk(sw_en == 0, "R5 switch stays off", int'(sw_en), 0);

    // R6/R7/R9: fixed limit, latching, continuous over-current from switch-on
    go_on();
    measure(1'b1, n);
    chk(n == FIX + 1, "R6 R7 on-time fixed limit", n, FIX + 1);
    chk(tripped == 1 && exhausted == 0, "R9 tripped flag", int'(tripped), 1);
    cyc(100);
    chk(sw_en == 0, "R9 latched off with command held", int'(sw_en), 0);
    cmd_on = 1'b0;
    cyc(5);
    chk(sw_en == 0 && tripped == 1, "R9 latched with command low", int'(tripped), 1);
    oc = 1'b0;
    cmd_on = 1'b1;
    cyc(1);
    chk(sw_en == 1 && tripped == 0, "R2 rise re-arms", int'(sw_en), 1);
    chk(acc == 0, "R2 rise clears acc", int'(acc), 0);
    cmd_on = 1'b0;
    cyc(1);
    chk(sw_en == 0, "R2 command low turns off", int'(sw_en), 0);

    // R3/R4: sweep of burst length N and quiet time m
    for (int nb = 1; nb <= 12; nb++) begin
      for (int m = 0; m <= 20; m++) begin
        int exp_acc;
        oc = 1'b0;
        go_on();
        oc = 1'b1;
        cyc(nb);
        if (m == 0) chk(acc == nb, "R3 count up per clock", int'(acc), nb);
        oc = 1'b0;
        cyc(m);
        exp_acc = nb - m / DIV;
        if (exp_acc < 0) exp_acc = 0;
        chk(acc == exp_acc, "R4 decay every DIV clocks", int'(acc), exp_acc);
      end
    end

    // R3: bursts of 8 with gaps of 4 accumulate to a trip in the sixth burst
    oc = 1'b0;
    go_on();
    for (int p = 1; p <= 5; p++) begin
      oc = 1'b1;
      cyc(8);
      oc = 1'b0;
      cyc(4);
    end
    chk(acc == 35, "R3 cumulative acc", int'(acc), 35);
    chk(sw_en == 1, "R3 not yet tripped", int'(sw_en), 1);
    oc = 1'b1;
    cyc(8);
    oc = 1'b0;
    chk(sw_en == 0 && tripped == 1, "R3 cumulative trip", int'(sw_en), 0);

    // R8: voltage-dependent limit over every drop code
    vdep_mode = 1'b1;
    for (int d = 0; d < 64; d++) begin
      int p, lim;
      cmd_on = 1'b0;
      drop = DROP_W'(d);
      p = 0;
      for (int b = 0; b < DROP_W; b++) if (d[b]) p = b;
      lim = BASE >> p;
      oc = 1'b1;
      go_on();
      measure(1'b1, n);
      chk(n == lim + 1, "R8 on-time with drop code", n, lim + 1);
    end
    vdep_mode = 1'b0;
    drop = '0;

    // R10/R11: retry sweep over off time and retry limit
    retry_mode = 1'b1;
    foreach (off_time[i]) begin end
    for (int ti = 0; ti < 4; ti++) begin
      for (int mi = 0; mi < 3; mi++) begin
        int tv, mv, exp_off;
        tv = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 3 : 7;
        mv = (mi == 0) ? 0 : (mi == 1) ? 1 : 3;
        exp_off = (tv == 0) ? 1 : tv;
        cmd_on = 1'b0;
        off_time = OFF_W'(tv);
        max_retry = TRY_W'(mv);
        oc = 1'b1;
        go_on();
        for (int k = 0; k <= mv; k++) begin
          measure(1'b1, n);
          chk(n == FIX + 1, "R10 on-time per attempt", n, FIX + 1);
          if (k < mv) begin
            chk(tripped == 1 && exhausted == 0, "R10 waiting flags", int'(exhausted), 0);
            measure(1'b0, n);
            chk(n == exp_off, "R10 off time", n, exp_off);
          end
        end
        chk(exhausted == 1 && tripped == 1, "R11 exhausted after retries", int'(exhausted), 1);
        cyc(60);
        chk(sw_en == 0, "R11 locked off", int'(sw_en), 0);
      end
    end
    retry_mode = 1'b0;
    oc = 1'b0;

    // R12: bistable fold-back
    fold_mode = 1'b1;
    go_on();
    chk(trickle == 0, "R12 trickle clear at start", int'(trickle), 0);
    oc = 1'b1;
    cyc(1);
    chk(trickle == 1, "R12 trickle set on overload", int'(trickle), 1);
    cyc(4);
    oc = 1'b0;
    cyc(5 * DIV);
    chk(acc == 0 && trickle == 1, "R12 trickle held until drained", int'(trickle), 1);
    cyc(1);
    chk(trickle == 0, "R12 trickle released", int'(trickle), 0);
    fold_mode = 1'b0;
    go_on();
    oc = 1'b1;
    cyc(3);
    chk(trickle == 0, "R12 no trickle when fold off", int'(trickle), 0);
    oc = 1'b0;
    cmd_on = 1'b0;
    cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule